// File: doc/BRIEF.md
# Word-wide GPIO register block

This block is a 32-bit general-purpose I/O controller attached to a simple word-wide read/write bus. It keeps three pieces of state: a pin-level register, a direction register and one spare auxiliary register. The level register drives the pin output data and the direction register drives the pin output enables, where a 1 marks a pin as an output. Software changes the level register through two write-only ports. One port sets bits and the other clears them. Both are gated by the direction register.

A set or clear write is applied only when the written mask overlaps at least one output-configured pin. When it is applied, the entire mask takes effect, and that includes bits that sit on input pins. A write that overlaps no output pin leaves the level register unchanged and produces a one-cycle input-write error pulse. The three edge-control addresses are accepted, but writes to them change nothing. Any other unknown address produces a one-cycle bad-read or bad-write pulse, in the same cycle as the strobe. Read data is registered. The nine interrupt outputs, eight for pins 0 to 7 and one shared line for the upper pins, are held low.

Top module: `gpio_regblock`

## Requirements
- R1: After reset the level, direction and auxiliary registers are zero, so `pin_out`, `pin_oe` and `bus_rdata` are zero and all error flags are low.
- R2: A write to byte offset 0x04 loads the direction register, which appears on `pin_oe` in the following cycle. A read of offset 0x04 returns it.
- R3: A write to offset 0x08 whose data ANDed with the direction register is non-zero ORs the whole written word into the level register, including bits on input pins. The result is visible on `pin_out` the next cycle.
- R4: A write to offset 0x0C whose data ANDed with the direction register is non-zero clears every written bit in the level register, including bits on input pins.
- R5: A write to offset 0x08 or 0x0C whose data does not overlap the direction register leaves the level register unchanged. It raises `err_input_wr` in the strobe cycle only.
- R6: Offset 0x20 is a read/write auxiliary register. Writing it changes neither `pin_out` nor `pin_oe`.
- R7: Writes to offsets 0x10, 0x14 and 0x18 change no register and raise no error flag.
- R8: A write to any other offset raises `err_bad_wr` in the strobe cycle only and changes no register.
- R9: Offsets 0x00 (level), 0x04 and 0x20 return their register on `bus_rdata` one cycle after the read strobe. `bus_rdata` holds its value while no read is made.
- R10: A read of any offset other than 0x00, 0x04 or 0x20 returns zero one cycle later. It raises `err_bad_rd` in the strobe cycle only. This includes the set and clear ports.
- R11: `irq_low` and `irq_high` are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | W (32) | Write data |
| bus_rdata | output | W (32) | Registered read data |
| pin_out | output | W (32) | Pin output data (level register) |
| pin_oe | output | W (32) | Pin output enables (direction register) |
| err_bad_rd | output | 1 | Pulse: read of an unmapped offset |
| err_bad_wr | output | 1 | Pulse: write to an unmapped offset |
| err_input_wr | output | 1 | Pulse: set/clear write that hit no output pin |
| irq_low | output | IRQ_LOW (8) | Per-pin interrupts for pins 0..7, tied low |
| irq_high | output | 1 | Shared interrupt for upper pins, tied low |

## Verification
The checker watches several properties on every cycle:
- the direction-register load;
- the gated set and clear results on `pin_out`;
- the level register staying unchanged on a non-overlapping set or clear;
- the absence of any register change or write error without a write strobe;
- `bus_rdata` holding between reads;
- the tied-off interrupts.

The bench sweeps every word offset with both writes and reads against an arithmetic model. This shows, in ways the cycle properties cannot, the full decode of unmapped and edge-control offsets and the exact read-data values. Per-bit direction sweeps show that a gated write applies its whole mask, including the input-pin bits.

// File: rtl/gpio_regblock_pkg.sv
// Package: shared offsets and decoded access kinds for the GPIO register block.
// Assumes byte offsets on a word-wide bus; all offsets fit in 8 bits.
package gpio_regblock_pkg;
    localparam int unsigned OFS_LEVEL = 32'h00;
    localparam int unsigned OFS_DIR   = 32'h04;
    localparam int unsigned OFS_SET   = 32'h08;
    localparam int unsigned OFS_CLR   = 32'h0C;
    localparam int unsigned OFS_EDGE0 = 32'h10;
    localparam int unsigned OFS_EDGE1 = 32'h14;
    localparam int unsigned OFS_EDGE2 = 32'h18;
    localparam int unsigned OFS_AUX   = 32'h20;

    typedef enum logic [2:0] {
        WK_NONE, WK_DIR, WK_SET, WK_CLR, WK_AUX, WK_EDGE, WK_BAD
    } wr_kind_t;

    typedef enum logic [2:0] {
        RK_NONE, RK_LEVEL, RK_DIR, RK_AUX, RK_BAD
    } rd_kind_t;
endpackage

// File: rtl/gpio_decode.sv
// Module: gpio_decode
// Purely combinational address decoder. It classifies the current write and
// read strobes into access kinds. Assumes at most one write and one read per cycle.
module gpio_decode
    import gpio_regblock_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output wr_kind_t          wr_kind,
    output rd_kind_t          rd_kind
);
    // Classify a write strobe by offset.
    always_comb begin
        wr_kind = WK_NONE;
        if (wr) begin
            if (addr == ADDR_W'(OFS_DIR))        wr_kind = WK_DIR;
            else if (addr == ADDR_W'(OFS_SET))   wr_kind = WK_SET;
            else if (addr == ADDR_W'(OFS_CLR))   wr_kind = WK_CLR;
            else if (addr == ADDR_W'(OFS_AUX))   wr_kind = WK_AUX;
            else if (addr == ADDR_W'(OFS_EDGE0) || addr == ADDR_W'(OFS_EDGE1) ||
                     addr == ADDR_W'(OFS_EDGE2)) wr_kind = WK_EDGE;
            else                                 wr_kind = WK_BAD;
        end
    end

    // Classify a read strobe by offset.
    always_comb begin
        rd_kind = RK_NONE;
        if (rd) begin
            if (addr == ADDR_W'(OFS_LEVEL))      rd_kind = RK_LEVEL;
            else if (addr == ADDR_W'(OFS_DIR))   rd_kind = RK_DIR;
            else if (addr == ADDR_W'(OFS_AUX))   rd_kind = RK_AUX;
            else                                 rd_kind = RK_BAD;
        end
    end
endmodule

// File: rtl/gpio_regs.sv
// Module: gpio_regs
// Holds the level, direction and auxiliary registers.
// Set and clear updates are gated on overlap with the direction register.
// When the gate passes, the full mask is applied.
// Assumes synchronous active-low reset to zero.
module gpio_regs
    import gpio_regblock_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wr_kind_t     wr_kind,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] level,
    output logic [W-1:0] dir,
    output logic [W-1:0] aux,
    output logic         input_err
);
    logic hits_output;

    // Does the written mask touch any output-configured pin?
    always_comb hits_output = |(wdata & dir);

    // Flag set/clear writes that touch no output pin.
    always_comb input_err = (wr_kind == WK_SET || wr_kind == WK_CLR) && !hits_output;

    // Register updates per decoded write kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            dir   <= '0;
            aux   <= '0;
        end else begin
            unique case (wr_kind)
                WK_DIR: dir <= wdata;
                WK_AUX: aux <= wdata;
                WK_SET: if (hits_output) level <= level | wdata;
                WK_CLR: if (hits_output) level <= level & ~wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_readback.sv
// Module: gpio_readback
// Registered read-data mux. Data is returned one cycle after the strobe
// and held between reads. Unmapped reads return zero.
module gpio_readback
    import gpio_regblock_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  rd_kind_t     rd_kind,
    input  logic [W-1:0] level,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] aux,
    output logic [W-1:0] rdata
);
    // Capture the selected register on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            unique case (rd_kind)
                RK_LEVEL: rdata <= level;
                RK_DIR:   rdata <= dir;
                RK_AUX:   rdata <= aux;
                RK_BAD:   rdata <= '0;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_regblock.sv
// Module: gpio_regblock (top)
// A 32-bit register-mapped GPIO controller. The level register drives the
// pin data and the direction register drives the output enables.
// Interrupt outputs are tied inactive.
// Assumes whole-word accesses only.
module gpio_regblock
    import gpio_regblock_pkg::*;
#(
    parameter int W       = 32,
    parameter int ADDR_W  = 8,
    parameter int IRQ_LOW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [W-1:0]       bus_wdata,
    output logic [W-1:0]       bus_rdata,
    output logic [W-1:0]       pin_out,
    output logic [W-1:0]       pin_oe,
    output logic               err_bad_rd,
    output logic               err_bad_wr,
    output logic               err_input_wr,
    output logic [IRQ_LOW-1:0] irq_low,
    output logic               irq_high
);
    wr_kind_t     wr_kind;
    rd_kind_t     rd_kind;
    logic [W-1:0] level, dir, aux;

    gpio_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wr_kind(wr_kind), .rd_kind(rd_kind)
    );

    gpio_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_kind(wr_kind), .wdata(bus_wdata),
        .level(level), .dir(dir), .aux(aux), .input_err(err_input_wr)
    );

    gpio_readback #(.W(W)) u_rb (
        .clk(clk), .rst_n(rst_n), .rd_kind(rd_kind),
        .level(level), .dir(dir), .aux(aux), .rdata(bus_rdata)
    );

    // Drive pins and the access error pulses.
    always_comb begin
        pin_out    = level;
        pin_oe     = dir;
        err_bad_wr = (wr_kind == WK_BAD);
        err_bad_rd = (rd_kind == RK_BAD);
    end

    // Interrupt lines exist but are never raised.
    for (genvar gi = 0; gi < IRQ_LOW; gi++) begin : g_irq_tie
        assign irq_low[gi] = 1'b0;
    end
    assign irq_high = 1'b0;
endmodule

// File: rtl/gpio_regblock_chk.sv
// Module: gpio_regblock_chk
// Cycle properties on the GPIO block's ports. Bound to every gpio_regblock.
module gpio_regblock_chk
    import gpio_regblock_pkg::*;
#(
    parameter int W       = 32,
    parameter int ADDR_W  = 8,
    parameter int IRQ_LOW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [W-1:0]       bus_wdata,
    input logic [W-1:0]       bus_rdata,
    input logic [W-1:0]       pin_out,
    input logic [W-1:0]       pin_oe,
    input logic               err_bad_wr,
    input logic               err_input_wr,
    input logic [IRQ_LOW-1:0] irq_low,
    input logic               irq_high
);
    logic wr_set, wr_clr;
    always_comb wr_set = bus_wr && bus_addr == ADDR_W'(OFS_SET);
    always_comb wr_clr = bus_wr && bus_addr == ADDR_W'(OFS_CLR);

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(OFS_DIR) |=> pin_oe == $past(bus_wdata)); // R2
    AST_SET_WHOLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set && |(bus_wdata & pin_oe) |=> pin_out == ($past(pin_out) | $past(bus_wdata))); // R3
    AST_CLR_WHOLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr && |(bus_wdata & pin_oe) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata))); // R4
    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set || wr_clr) && !(|(bus_wdata & pin_oe)) |=> $stable(pin_out)); // R5
    AST_GATED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set || wr_clr) && !(|(bus_wdata & pin_oe)) |-> err_input_wr); // R5
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pin_out) && $stable(pin_oe)); // R8
    AST_IDLE_NO_WR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |-> !err_bad_wr && !err_input_wr); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_low == '0 && !irq_high); // R11
endmodule

bind gpio_regblock gpio_regblock_chk #(.W(W), .ADDR_W(ADDR_W), .IRQ_LOW(IRQ_LOW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .err_bad_wr(err_bad_wr),
    .err_input_wr(err_input_wr), .irq_low(irq_low), .irq_high(irq_high)
);

// File: tb/gpio_regblock_test.sv
// Bench for gpio_regblock.
// Drives all inputs at the falling edge and samples 1 time unit later.
module gpio_regblock_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, pin_out, pin_oe;
    logic        err_bad_rd, err_bad_wr, err_input_wr, irq_high;
    logic [7:0]  irq_low;

    int checks = 0, fails = 0;
    logic [31:0] m_level = '0, m_dir = '0, m_aux = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_regblock uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_out(pin_out), .pin_oe(pin_oe), .err_bad_rd(err_bad_rd),
        .err_bad_wr(err_bad_wr), .err_input_wr(err_input_wr),
        .irq_low(irq_low), .irq_high(irq_high)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write one word, update the model, check flags in the strobe cycle and pins after.
    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        bit e_in = 0, e_bad = 0;
        string req;
        case (a)
            8'h04: begin m_dir = d; req = "R2 dir write"; end
            8'h08: if (|(d & m_dir)) begin m_level |= d; req = "R3 set"; end
                   else begin e_in = 1; req = "R5 set gated"; end
            8'h0C: if (|(d & m_dir)) begin m_level &= ~d; req = "R4 clear"; end
                   else begin e_in = 1; req = "R5 clear gated"; end
            8'h20: begin m_aux = d; req = "R6 aux write"; end
            8'h10, 8'h14, 8'h18: req = "R7 edge write";
            default: begin e_bad = 1; req = "R8 bad write"; end
        endcase
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        check(err_input_wr == e_in, {req, " err_input_wr"}, 32'(err_input_wr), 32'(e_in));
        check(err_bad_wr == e_bad, {req, " err_bad_wr"}, 32'(err_bad_wr), 32'(e_bad));
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        check(err_input_wr == 1'b0 && err_bad_wr == 1'b0, {req, " pulse ends"},
              32'({err_input_wr, err_bad_wr}), 32'd0);
        check(pin_out == m_level, {req, " pin_out"}, pin_out, m_level);
        check(pin_oe == m_dir, {req, " pin_oe"}, pin_oe, m_dir);
    endtask

    // Read one word and check the flag in the strobe cycle and the data one cycle later.
    task automatic do_rd(input logic [7:0] a);
        logic [31:0] exp;
        bit bad = 0;
        string req = "R9 read";
        case (a)
            8'h00: exp = m_level;
            8'h04: exp = m_dir;
            8'h20: begin exp = m_aux; req = "R6 aux read"; end
            default: begin exp = '0; bad = 1; req = "R10 bad read"; end
        endcase
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        check(err_bad_rd == bad, {req, " err_bad_rd"}, 32'(err_bad_rd), 32'(bad));
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
        check(bus_rdata == exp, {req, " rdata"}, bus_rdata, exp);
        check(err_bad_rd == 1'b0, {req, " pulse ends"}, 32'(err_bad_rd), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(pin_out == 0 && pin_oe == 0 && bus_rdata == 0, "R1 reset outputs",
              pin_out | pin_oe | bus_rdata, 32'd0);
        check(!err_bad_rd && !err_bad_wr && !err_input_wr, "R1 reset flags",
              32'({err_bad_rd, err_bad_wr, err_input_wr}), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        do_rd(8'h20);   // R1 auxiliary register also resets to zero
        do_rd(8'h00);
        do_wr(8'h08, 32'hFFFF_FFFF);   // R5: no output pins yet
        do_wr(8'h04, 32'h0000_FFFF);

        // Sweep every word offset with a write then a read.
        for (int w = 0; w < 64; w++) begin
            do_wr(8'(w * 4), 32'h9E37_79B9 * 32'(w + 1));
            do_rd(8'(w * 4));
        end

        // Per-bit direction sweep: whole-mask apply and gating.
        for (int i = 0; i < 32; i++) begin
            logic [31:0] one  = 32'd1 << i;
            logic [31:0] far  = 32'd1 << ((i + 7) % 32);
            logic [31:0] near = 32'd1 << ((i + 3) % 32);
            do_wr(8'h04, one);
            do_wr(8'h0C, 32'hFFFF_FFFF);      // R4 full clear through one output bit
            do_wr(8'h08, one | far);          // R3 input bit 'far' also set
            do_wr(8'h08, near);               // R5 no overlap
            do_wr(8'h0C, near);               // R5 no overlap
            do_wr(8'h0C, one | far);          // R4 both bits cleared
            do_rd(8'h00);
        end

        // R7: edge writes leave aux untouched too.
        do_wr(8'h20, 32'hA5A5_0F0F);
        do_wr(8'h10, 32'hFFFF_FFFF);
        do_wr(8'h14, 32'h1234_5678);
        do_wr(8'h18, 32'h0);
        do_rd(8'h20);

        // R9: rdata holds across idle cycles.
        repeat (5) @(negedge clk);
        #1;
        check(bus_rdata == m_aux, "R9 rdata hold", bus_rdata, m_aux);
        check(irq_low == 8'h00 && irq_high == 1'b0, "R11 interrupts low",
              32'({irq_high, irq_low}), 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule